// File: doc/BRIEF.md
# Sticky Clear-on-Read Interrupt Status Register

This block holds the first interrupt status byte of a hardware monitor. Seven measurement channels report into it: three temperature sensors and four supply rails. Each channel supplies a level flag that is high while its latest reading is outside limits, and a strobe that pulses when its reading is refreshed. The block latches a channel's event into a sticky bit and decides when that bit may drop again. The measurement, the limit comparison and the host bus are handled elsewhere.

A bit drops in only two ways. The first is a host read, and only when the channel is no longer in violation. The second is the channel's individual enable being cleared, and then only at that channel's next reading refresh while the monitor is running. The top bit is not stored here. It mirrors, live, whether any bit of a second status register is set. The value presented to the host is the register as it stands before the read's clear takes effect. Host writes are ignored. Group and global interrupt enables pass through this block and do not touch it.

Top module: `sticky_irq_status`

## Requirements
- R1: After reset, bits 6..0 of `rdata` are 0, so with `st2_any` low the output reads 8'h00.
- R2: Channel bits map onto `rdata` as follows: bit 0 is 2.5V, bit 1 is Vccp, bit 2 is VCC, bit 3 is 5V, bit 4 is temperature D1, bit 5 is the ambient temperature and bit 6 is temperature D2. Channel i is bit i. The bit is 1 in the cycle after a clock edge at which `run`, `chan_upd[i]`, `chan_en[i]` and `chan_viol[i]` are all 1.
- R3: While `chan_en[i]` is 0, bit i never changes from 0 to 1, whatever `chan_viol[i]` and `chan_upd[i]` do.
- R4: A set bit stays 1 after `chan_viol[i]` falls, until it is released by a host read or by the disable path.
- R5: A clock edge with `host_rd` high clears each bit whose `chan_viol` is 0 at that edge and keeps each bit whose `chan_viol` is 1. `rdata` during the read cycle shows the value before the clear. A set arriving in the same cycle as a read takes precedence over the clear.
- R6: If `chan_en[i]` is 0 while bit i is 1, the bit clears at the first edge with `run` and `chan_upd[i]` both 1. Until then it stays 1, including through any period with `run` at 0.
- R7: `grp_en` and `glob_en` have no effect on any status bit, either on setting or on holding.
- R8: `rdata[7]` equals `st2_any` in the same cycle, combinationally, and is unaffected by reads.
- R9: `host_wr` and `host_wdata` have no effect on the register.
- R10: While `run` is 0, reading strobes neither set nor clear any bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Monitoring active; readings refresh only while 1 |
| chan_en | input | 7 | Individual interrupt enable per channel |
| chan_viol | input | 7 | Channel reading is currently outside limits (level) |
| chan_upd | input | 7 | Channel reading refreshed this cycle (pulse) |
| grp_en | input | 3 | Group enables for temperature, fan and voltage (ignored here) |
| glob_en | input | 1 | Global interrupt enable (ignored here) |
| host_rd | input | 1 | Host read of this register this cycle |
| host_wr | input | 1 | Host write to this register this cycle (ignored) |
| host_wdata | input | 8 | Host write data (ignored) |
| st2_any | input | 1 | Some bit of the second status register is set |
| rdata | output | 8 | Register value returned on a host read |

## Verification
The assertions assume that `chan_viol` is a level that is valid at every clock edge. They also assume that `host_rd` lasts one cycle per read, so that a held read is treated as repeated reads and not as an error. The directed bench keeps to these assumptions. It changes every input one time unit after a rising edge and pulses the read and update strobes for exactly one cycle. It holds reset over the first edges so that no property sees values from before reset.

// File: rtl/sticky_irq_status.sv
module sticky_irq_status #(
  parameter int NCH = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] chan_viol,
  input  logic [NCH-1:0] chan_upd,
  input  logic [2:0]     grp_en,
  input  logic           glob_en,
  input  logic           host_rd,
  input  logic           host_wr,
  input  logic [NCH:0]   host_wdata,
  input  logic           st2_any,
  output logic [NCH:0]   rdata
);

  logic [NCH-1:0] stat_q;
  logic [NCH-1:0] fresh;
  logic           unused_ok;

  assign fresh     = run ? chan_upd : '0;
  assign unused_ok = ^{grp_en, glob_en, host_wr, host_wdata};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit, drop_dis, drop_rd;
    assign hit      = fresh[i] &  chan_en[i] & chan_viol[i];
    assign drop_dis = fresh[i] & ~chan_en[i];
    assign drop_rd  = host_rd  & ~chan_viol[i];

    always_ff @(posedge clk) begin
      if (!rst_n)                stat_q[i] <= 1'b0;
      else if (hit)              stat_q[i] <= 1'b1;
      else if (drop_dis || drop_rd) stat_q[i] <= 1'b0;
    end
  end

  assign rdata = {st2_any, stat_q};

endmodule

module sticky_irq_status_chk #(
  parameter int NCH = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] chan_viol,
  input logic [NCH-1:0] chan_upd,
  input logic           host_rd,
  input logic [NCH:0]   rdata
);

  a_r1_reset_clear: assert property (@(posedge clk)
    (rst_n && !$past(rst_n)) |-> (rdata[NCH-1:0] == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
      (run && chan_upd[i] && chan_en[i] && chan_viol[i]) |=> rdata[i]);

    a_r3_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdata[i] && !chan_en[i]) |=> !rdata[i]);

    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata[i] && !host_rd && !(run && chan_upd[i] && !chan_en[i])) |=> rdata[i]);

    a_r5_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !chan_viol[i]) |=> !rdata[i]);

    a_r5_read_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && chan_viol[i] && rdata[i]) |=> rdata[i]);

    a_r6_disable_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (run && chan_upd[i] && !chan_en[i]) |=> !rdata[i]);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !host_rd) |=> $stable(rdata[i]));
  end

endmodule

bind sticky_irq_status sticky_irq_status_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .chan_en(chan_en),
  .chan_viol(chan_viol), .chan_upd(chan_upd), .host_rd(host_rd), .rdata(rdata)
);

// File: tb/test_sticky_irq_status.sv
module test_sticky_irq_status;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [6:0] chan_en = '0, chan_viol = '0, chan_upd = '0;
  logic [2:0] grp_en = 3'b111;
  logic       glob_en = 1'b1;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic       st2_any = 1'b0;
  logic [7:0] rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  sticky_irq_status i_sticky_irq_status (
    .clk(clk), .rst_n(rst_n), .run(run), .chan_en(chan_en), .chan_viol(chan_viol),
    .chan_upd(chan_upd), .grp_en(grp_en), .glob_en(glob_en), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .st2_any(st2_any), .rdata(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [7:0] exp);
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, rdata, exp);
    end
  endtask

  task automatic upd(logic [6:0] m);
    chan_upd = m;
    tick();
    chan_upd = '0;
  endtask

  task automatic rd();
    host_rd = 1'b1;
    tick();
    host_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset", 8'h00);
  endtask

  task automatic t_set_sticky();
    chan_en = 7'h7f; run = 1'b1;
    chan_viol = 7'h04; upd(7'h04);
    chk("R2 set VCC bit2", 8'h04);
    chan_viol = '0; upd(7'h04); tick(); tick();
    chk("R4 sticky after violation gone", 8'h04);
  endtask

  task automatic t_read();
    host_rd = 1'b1; #1;
    chk("R5 pre-clear read value", 8'h04);
    tick(); host_rd = 1'b0;
    chk("R5 cleared after read", 8'h00);
    chan_viol = 7'h41; upd(7'h41);
    chk("R2 set bits 6 and 0", 8'h41);
    chan_viol = 7'h40; rd();
    chk("R5 active bit kept, inactive cleared", 8'h40);
    chan_viol = '0; rd();
    chk("R5 cleared once inactive", 8'h00);
  endtask

  task automatic t_read_vs_set();
    chan_viol = 7'h02; chan_upd = 7'h02; host_rd = 1'b1;
    tick(); chan_upd = '0; host_rd = 1'b0;
    chk("R5 set wins over same-cycle read", 8'h02);
    chan_viol = '0; rd();
    chk("R5 clear after set", 8'h00);
  endtask

  task automatic t_disabled_no_set();
    chan_en = 7'h77; chan_viol = 7'h08; upd(7'h08);
    chk("R3 disabled channel not set", 8'h00);
    chan_viol = '0; chan_en = 7'h7f;
  endtask

  task automatic t_disable_clear();
    chan_viol = 7'h10; upd(7'h10);
    chk("R2 set D1 bit4", 8'h10);
    chan_viol = '0; chan_en = 7'h6f; run = 1'b0;
    upd(7'h10); tick();
    chk("R6 disabled bit held while not running", 8'h10);
    run = 1'b1; tick(); tick();
    chk("R6 disabled bit held until update", 8'h10);
    upd(7'h08);
    chk("R6 other channel update leaves bit", 8'h10);
    upd(7'h10);
    chk("R6 cleared at own update", 8'h00);
    chan_en = 7'h7f;
  endtask

  task automatic t_not_running();
    run = 1'b0; chan_viol = 7'h02; upd(7'h02);
    chk("R10 no set while not running", 8'h00);
    chan_viol = '0; run = 1'b1;
  endtask

  task automatic t_group_enables();
    grp_en = '0; glob_en = 1'b0;
    chan_viol = 7'h20; upd(7'h20);
    chk("R7 set with group/global enables off", 8'h20);
    chan_viol = '0; grp_en = 3'b111; glob_en = 1'b1; tick();
    grp_en = 3'b000; tick(); glob_en = 1'b0; tick();
    chk("R7 enable toggles leave bit", 8'h20);
    grp_en = 3'b111; glob_en = 1'b1;
    rd();
    chk("R7 clear by read", 8'h00);
  endtask

  task automatic t_summary();
    st2_any = 1'b1; #1;
    chk("R8 summary follows same cycle", 8'h80);
    rd();
    chk("R8 summary unaffected by read", 8'h80);
    st2_any = 1'b0; #1;
    chk("R8 summary drops", 8'h00);
  endtask

  task automatic t_write();
    host_wr = 1'b1; host_wdata = 8'hff; tick(); host_wr = 1'b0;
    chk("R9 write of ff ignored", 8'h00);
    chan_viol = 7'h01; upd(7'h01); chan_viol = '0;
    host_wr = 1'b1; host_wdata = 8'h00; tick(); host_wr = 1'b0;
    chk("R9 write of 00 ignored", 8'h01);
    rd();
  endtask

  initial begin
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_set_sticky();
    t_read();
    t_read_vs_set();
    t_disabled_no_set();
    t_disable_clear();
    t_not_running();
    t_group_enables();
    t_summary();
    t_write();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule